// File: doc/BRIEF.md
# Event Routing Channel Controller

This block carries single-cycle event pulses from one chosen generator to a group of event users, with one routing path for each channel. Each channel picks its generator through a select input. A software write can also inject an event, and the channel then handles it in the same way as a generator event. Each channel runs in one of three path modes. The asynchronous mode passes the pulse straight through with no registers. The synchronous mode registers it once. The resynchronized mode first brings it through a two-flop synchronizer and then an edge detector.

In the two clocked modes the channel keeps track of each connected user's acknowledge. From this it drives a busy status and a combined user-ready status. An event that arrives while the channel is still busy is dropped, and the channel records an overrun. Each channel has an overrun interrupt flag and an event-detected interrupt flag. Each flag has an enable bit. The enables are set and cleared through separate write-one addresses, and every enabled flag feeds one combined interrupt line.

Top module: `evchan_ctrl`

## Requirements
- R1: In synchronous mode (path code 2'b01, and 2'b11 also maps here), a source pulse sampled at a clock edge comes out on `evt_out` in the following cycle, one cycle wide.
- R2: In resynchronized mode (path code 2'b10), a source pulse sampled at edge k comes out as a single-cycle output pulse registered at edge k+2. A source held high for several cycles still gives only one output pulse.
- R3: In asynchronous mode (path code 2'b00), `evt_out` follows the selected source in the same cycle. The channel never goes busy and never records a detected event.
- R4: A write to address 0 with data bit c set injects an event on channel c in that cycle, and the event is handled in the same way as a generator event.
- R5: In a clocked mode, `ch_busy` goes high in the cycle after an event is accepted, provided at least one user is connected. It stays high until every connected user has acknowledged, and falls in the cycle after the last acknowledge is sampled. Users that are not connected do not count.
- R6: `ch_ready` is high only when the channel is in a clocked mode and every connected user has its ready input high. The ready inputs of users that are not connected are ignored.
- R7: An event that reaches a busy channel is not forwarded, and it sets overrun flag bit c.
- R8: Every accepted event in a clocked mode sets detected flag bit NUM_CH+c. This flag never rises in asynchronous mode.
- R9: A write of 1 to a bit at address 1 sets that interrupt enable bit. A write of 1 to a bit at address 2 clears it. Bits written with 0 keep their value.
- R10: A write of 1 to a bit at address 3 clears that flag bit. If a set condition occurs in the same cycle as the clear, the set wins.
- R11: `irq` is high exactly when some flag bit and its enable bit are both set. It falls once the flag is cleared or the enable is removed.
- R12: After reset, all flags, all enables, busy, `evt_out` and `irq` are zero.
- R13: Each channel listens only to the generator that its select field names.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gen_evt | input | NUM_GEN | Generator event pulses |
| ch_gen_sel | input | NUM_CH*SEL_W | Per-channel generator select |
| ch_path | input | 2*NUM_CH | Per-channel path mode code |
| usr_conn | input | NUM_CH*NUM_USR | Users connected to each channel |
| usr_ready | input | NUM_CH*NUM_USR | User ready inputs |
| usr_ack | input | NUM_CH*NUM_USR | User acknowledge pulses |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address (0 soft event, 1 enable set, 2 enable clear, 3 flag clear) |
| wr_data | input | 2*NUM_CH | Register write data |
| evt_out | output | NUM_CH | Event pulse to each channel's users |
| ch_busy | output | NUM_CH | Channel awaiting acknowledges |
| ch_ready | output | NUM_CH | All connected users ready |
| int_flag | output | 2*NUM_CH | Flags: overrun at bit c, detected at bit NUM_CH+c |
| int_en | output | 2*NUM_CH | Interrupt enables, same layout |
| irq | output | 1 | Combined interrupt request |

## Verification
Two functions can fall in the same clock edge. A flag clear can meet a flag set, and the bench causes this by writing the overrun clear bit in the very cycle that a second generator pulse hits a busy channel. The bench also does the same with a detected-flag clear and a newly accepted event. In both cases the flag must still read 1 afterwards, and a later clear on its own must then remove it. The bench also watches `evt_out` and `ch_busy` cycle by cycle across acknowledges and across the resynchronizer delay.

// File: rtl/evchan_pkg.sv
package evchan_pkg;

    typedef enum logic [1:0] {
        PATH_ASYNC  = 2'b00,
        PATH_SYNC   = 2'b01,
        PATH_RESYNC = 2'b10
    } path_e;

    typedef enum logic [1:0] {
        REG_SWEVT   = 2'd0,
        REG_ENSET   = 2'd1,
        REG_ENCLR   = 2'd2,
        REG_FLAGCLR = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic evt;
        logic busy;
        logic ready;
        logic ovr_set;
        logic det_set;
    } ch_status_t;

    // Unused code 2'b11 falls back to the single-register path.
    function automatic path_e path_decode(input logic [1:0] code);
        case (code)
            2'b00:   return PATH_ASYNC;
            2'b10:   return PATH_RESYNC;
            default: return PATH_SYNC;
        endcase
    endfunction

    function automatic logic path_tracked(input path_e p);
        return p != PATH_ASYNC;
    endfunction

endpackage

// File: rtl/evchan_regif.sv
module evchan_regif
    import evchan_pkg::*;
#(
    parameter int NUM_CH = 2,
    localparam int REG_W = 2 * NUM_CH
) (
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    output logic [NUM_CH-1:0] sw_evt,
    output logic [REG_W-1:0]  en_set,
    output logic [REG_W-1:0]  en_clr,
    output logic [REG_W-1:0]  flag_clr
);

    reg_addr_e addr;
    assign addr = reg_addr_e'(wr_addr);

    always_comb begin
        sw_evt   = '0;
        en_set   = '0;
        en_clr   = '0;
        flag_clr = '0;
        if (wr_en) begin
            unique case (addr)
                REG_SWEVT:   sw_evt   = wr_data[NUM_CH-1:0];
                REG_ENSET:   en_set   = wr_data;
                REG_ENCLR:   en_clr   = wr_data;
                REG_FLAGCLR: flag_clr = wr_data;
            endcase
        end
    end

endmodule

// File: rtl/evchan_path.sv
module evchan_path
    import evchan_pkg::*;
#(
    parameter int NUM_GEN = 4,
    parameter int NUM_USR = 3,
    parameter int SEL_W   = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_GEN-1:0] gen_evt,
    input  logic [SEL_W-1:0]   gen_sel,
    input  logic [1:0]         path_code,
    input  logic               sw_evt,
    input  logic [NUM_USR-1:0] usr_conn,
    input  logic [NUM_USR-1:0] usr_ready,
    input  logic [NUM_USR-1:0] usr_ack,
    output ch_status_t         st
);

    localparam logic [SEL_W:0] GEN_LIM = (SEL_W + 1)'(NUM_GEN);
    localparam int SYNC_DEPTH = 3;

    path_e               mode;
    logic                gen_hit;
    logic                raw;
    logic                cand;
    logic                busy;
    logic                accept;
    logic                overrun;
    logic                evt_q;
    logic [SYNC_DEPTH-1:0] sync_q;
    logic [NUM_USR-1:0]  pend_q;

    assign mode    = path_decode(path_code);
    assign gen_hit = ({1'b0, gen_sel} < GEN_LIM) ? gen_evt[gen_sel] : 1'b0;
    assign raw     = gen_hit | sw_evt;

    // Candidate event seen by the tracking logic, per path flavour.
    always_comb begin
        case (mode)
            PATH_SYNC:   cand = raw;
            PATH_RESYNC: cand = sync_q[1] & ~sync_q[2];
            default:     cand = 1'b0;
        endcase
    end

    assign busy    = |pend_q;
    assign accept  = cand & ~busy;
    assign overrun = cand & busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            evt_q  <= 1'b0;
            pend_q <= '0;
        end else begin
            sync_q <= {sync_q[SYNC_DEPTH-2:0], raw};
            evt_q  <= accept;
            if (accept) begin
                pend_q <= usr_conn;
            end else begin
                pend_q <= pend_q & ~usr_ack;
            end
        end
    end

    always_comb begin
        st         = '0;
        st.evt     = (mode == PATH_ASYNC) ? raw : evt_q;
        st.busy    = busy;
        st.ready   = path_tracked(mode) & (&(usr_ready | ~usr_conn));
        st.ovr_set = overrun;
        st.det_set = accept;
    end

    AST_SYNC_LATENCY: assert property (@(posedge clk) disable iff (rst)
        (mode == PATH_SYNC && raw && !busy) |=> evt_q); // R1

    AST_RESYNC_SINGLE: assert property (@(posedge clk) disable iff (rst)
        (mode == PATH_RESYNC && $stable(mode) && evt_q) |=> !evt_q); // R2

    AST_BUSY_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (busy && ((pend_q & ~usr_ack) == '0)) |=> !busy); // R5

    AST_DROP_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        (path_tracked(mode) && busy) |=> !evt_q); // R7

endmodule

// File: rtl/evchan_irq.sv
module evchan_irq #(
    parameter int REG_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [REG_W-1:0] set_v,
    input  logic [REG_W-1:0] flag_clr,
    input  logic [REG_W-1:0] en_set,
    input  logic [REG_W-1:0] en_clr,
    output logic [REG_W-1:0] flag_q,
    output logic [REG_W-1:0] en_q,
    output logic             irq
);

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= '0;
            en_q   <= '0;
        end else begin
            flag_q <= (flag_q & ~flag_clr) | set_v;
            en_q   <= (en_q | en_set) & ~en_clr;
        end
    end

    assign irq = |(flag_q & en_q);

    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        (set_v != '0) |=> ((flag_q & $past(set_v)) == $past(set_v))); // R10

    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (rst)
        (set_v == '0 && flag_clr == '0) |=> (flag_q == $past(flag_q))); // R10

    AST_EN_SET: assert property (@(posedge clk) disable iff (rst)
        (en_set != '0 && en_clr == '0) |=> ((en_q & $past(en_set)) == $past(en_set))); // R9

    AST_EN_CLR: assert property (@(posedge clk) disable iff (rst)
        (en_clr != '0) |=> ((en_q & $past(en_clr)) == '0)); // R9

endmodule

// File: rtl/evchan_ctrl.sv
module evchan_ctrl
    import evchan_pkg::*;
#(
    parameter int NUM_CH  = 2,
    parameter int NUM_GEN = 4,
    parameter int NUM_USR = 3,
    localparam int SEL_W  = (NUM_GEN > 1) ? $clog2(NUM_GEN) : 1,
    localparam int REG_W  = 2 * NUM_CH
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [NUM_GEN-1:0]         gen_evt,
    input  logic [NUM_CH*SEL_W-1:0]    ch_gen_sel,
    input  logic [2*NUM_CH-1:0]        ch_path,
    input  logic [NUM_CH*NUM_USR-1:0]  usr_conn,
    input  logic [NUM_CH*NUM_USR-1:0]  usr_ready,
    input  logic [NUM_CH*NUM_USR-1:0]  usr_ack,
    input  logic                       wr_en,
    input  logic [1:0]                 wr_addr,
    input  logic [REG_W-1:0]           wr_data,
    output logic [NUM_CH-1:0]          evt_out,
    output logic [NUM_CH-1:0]          ch_busy,
    output logic [NUM_CH-1:0]          ch_ready,
    output logic [REG_W-1:0]           int_flag,
    output logic [REG_W-1:0]           int_en,
    output logic                       irq
);

    logic [NUM_CH-1:0] sw_evt;
    logic [REG_W-1:0]  en_set;
    logic [REG_W-1:0]  en_clr;
    logic [REG_W-1:0]  flag_clr;
    logic [NUM_CH-1:0] ovr_v;
    logic [NUM_CH-1:0] det_v;
    ch_status_t        st [NUM_CH];

    evchan_regif #(.NUM_CH(NUM_CH)) regif_i (
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .sw_evt   (sw_evt),
        .en_set   (en_set),
        .en_clr   (en_clr),
        .flag_clr (flag_clr)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        evchan_path #(
            .NUM_GEN (NUM_GEN),
            .NUM_USR (NUM_USR),
            .SEL_W   (SEL_W)
        ) path_i (
            .clk       (clk),
            .rst       (rst),
            .gen_evt   (gen_evt),
            .gen_sel   (ch_gen_sel[SEL_W*c +: SEL_W]),
            .path_code (ch_path[2*c +: 2]),
            .sw_evt    (sw_evt[c]),
            .usr_conn  (usr_conn[NUM_USR*c +: NUM_USR]),
            .usr_ready (usr_ready[NUM_USR*c +: NUM_USR]),
            .usr_ack   (usr_ack[NUM_USR*c +: NUM_USR]),
            .st        (st[c])
        );

        assign evt_out[c]  = st[c].evt;
        assign ch_busy[c]  = st[c].busy;
        assign ch_ready[c] = st[c].ready;
        assign ovr_v[c]    = st[c].ovr_set;
        assign det_v[c]    = st[c].det_set;

        AST_ASYNC_NO_DET: assert property (@(posedge clk) disable iff (rst)
            $rose(int_flag[NUM_CH+c]) |-> ($past(ch_path[2*c +: 2]) != 2'b00)); // R8
    end

    evchan_irq #(.REG_W(REG_W)) irq_i (
        .clk      (clk),
        .rst      (rst),
        .set_v    ({det_v, ovr_v}),
        .flag_clr (flag_clr),
        .en_set   (en_set),
        .en_clr   (en_clr),
        .flag_q   (int_flag),
        .en_q     (int_en),
        .irq      (irq)
    );

endmodule

// File: tb/evchan_ctrl_tb.sv
`timescale 1ns/1ps
module evchan_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] gen_evt = '0;
    logic [3:0] ch_gen_sel = '0;
    logic [3:0] ch_path = 4'b0101;
    logic [5:0] usr_conn = '0;
    logic [5:0] usr_ready = '0;
    logic [5:0] usr_ack = '0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [3:0] wr_data = '0;
    logic [1:0] evt_out;
    logic [1:0] ch_busy;
    logic [1:0] ch_ready;
    logic [3:0] int_flag;
    logic [3:0] int_en;
    logic       irq;

    int n_chk = 0;
    int n_err = 0;

    always #2.5 clk = ~clk;

    evchan_ctrl dut_i (
        .clk(clk), .rst(rst), .gen_evt(gen_evt), .ch_gen_sel(ch_gen_sel),
        .ch_path(ch_path), .usr_conn(usr_conn), .usr_ready(usr_ready),
        .usr_ack(usr_ack), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .evt_out(evt_out), .ch_busy(ch_busy), .ch_ready(ch_ready),
        .int_flag(int_flag), .int_en(int_en), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic nx();
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [3:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        nx();
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic cfg(input logic [3:0] path, input logic [3:0] sel, input logic [5:0] conn);
        ch_path = path; ch_gen_sel = sel; usr_conn = conn;
        usr_ack = '0; usr_ready = '0; gen_evt = '0;
        nx(); nx(); nx();
        wr(2'd3, 4'hF);
        wr(2'd2, 4'hF);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        nx(); nx(); nx();
        rst = 1'b0;
        chk("R12 evt_out", evt_out, 0);
        chk("R12 busy", ch_busy, 0);
        chk("R12 flags", int_flag, 0);
        chk("R12 enables", int_en, 0);
        chk("R12 irq", irq, 0);
    endtask

    task automatic t_sync_select();
        cfg(4'b0101, 4'b1000, 6'b0);
        gen_evt = 4'b0001;
        nx();
        gen_evt = '0;
        chk("R1 pulse next cycle", evt_out, 2'b01);
        chk("R8 detected ch0", int_flag[2], 1);
        nx();
        chk("R1 one cycle wide", evt_out, 2'b00);
        gen_evt = 4'b0100;
        nx();
        gen_evt = 4'b0010;
        chk("R13 ch1 gets gen2 only", evt_out, 2'b10);
        nx();
        gen_evt = '0;
        chk("R13 gen1 unselected", evt_out, 2'b00);
    endtask

    task automatic t_resync();
        int pulses = 0;
        cfg(4'b0110, 4'b0000, 6'b0);
        gen_evt = 4'b0001;
        nx(); chk("R2 not yet k", evt_out[0], 0);
        nx(); chk("R2 not yet k+1", evt_out[0], 0);
        nx(); chk("R2 pulse at k+2", evt_out[0], 1);
        pulses = 1;
        gen_evt = '0;
        for (int i = 0; i < 6; i++) begin
            nx();
            if (evt_out[0]) pulses++;
        end
        chk("R2 single pulse for held source", pulses, 1);
    endtask

    task automatic t_async();
        cfg(4'b0100, 4'b0000, 6'b000001);
        usr_ready = 6'b000001;
        gen_evt = 4'b0001;
        #1;
        chk("R3 same-cycle pass", evt_out[0], 1);
        chk("R6 not ready in async", ch_ready[0], 0);
        nx();
        gen_evt = '0;
        #1;
        chk("R3 no pass after", evt_out[0], 0);
        chk("R3 no busy", ch_busy[0], 0);
        chk("R3 no detected flag", int_flag[2], 0);
    endtask

    task automatic t_soft();
        cfg(4'b0101, 4'b0000, 6'b0);
        wr(2'd0, 4'b0010);
        chk("R4 soft event ch1", evt_out, 2'b10);
        chk("R4 detected ch1", int_flag[3], 1);
        nx();
        chk("R4 single pulse", evt_out, 2'b00);
    endtask

    task automatic t_busy();
        cfg(4'b0101, 4'b0000, 6'b000011);
        gen_evt = 4'b0001;
        nx();
        gen_evt = '0;
        chk("R5 busy after accept", ch_busy[0], 1);
        usr_ack = 6'b000001;
        nx();
        usr_ack = 6'b000100;
        chk("R5 busy with one ack missing", ch_busy[0], 1);
        nx();
        usr_ack = 6'b000010;
        chk("R5 unconnected ack ignored", ch_busy[0], 1);
        nx();
        usr_ack = '0;
        chk("R5 released after last ack", ch_busy[0], 0);
    endtask

    task automatic t_ready();
        cfg(4'b0101, 4'b0000, 6'b000011);
        usr_ready = 6'b000001; #1;
        chk("R6 one user not ready", ch_ready[0], 0);
        usr_ready = 6'b000011; #1;
        chk("R6 all connected ready", ch_ready[0], 1);
        usr_ready = 6'b000110; #1;
        chk("R6 unconnected ready ignored", ch_ready[0], 0);
        chk("R6 no users connected", ch_ready[1], 1);
        nx();
    endtask

    task automatic t_overrun();
        cfg(4'b0101, 4'b0000, 6'b000001);
        gen_evt = 4'b0001;
        nx();
        chk("R7 first accepted", evt_out[0], 1);
        nx();
        gen_evt = '0;
        chk("R7 second dropped", evt_out[0], 0);
        chk("R7 overrun flag", int_flag[0], 1);
        usr_ack = 6'b000001;
        nx();
        usr_ack = '0;
        chk("R7 busy released", ch_busy[0], 0);
    endtask

    task automatic t_setwins();
        cfg(4'b0101, 4'b0000, 6'b000001);
        gen_evt = 4'b0001;
        nx();
        wr_en = 1'b1; wr_addr = 2'd3; wr_data = 4'b0001;
        nx();
        wr_en = 1'b0; gen_evt = '0;
        chk("R10 overrun set beats clear", int_flag[0], 1);
        usr_ack = 6'b000001;
        wr(2'd3, 4'b0001);
        usr_ack = '0;
        chk("R10 clear alone", int_flag[0], 0);
        nx();
        gen_evt = 4'b0001;
        wr_en = 1'b1; wr_addr = 2'd3; wr_data = 4'b0100;
        nx();
        wr_en = 1'b0; gen_evt = '0;
        chk("R10 detected set beats clear", int_flag[2], 1);
        usr_ack = 6'b000001;
        nx();
        usr_ack = '0;
    endtask

    task automatic t_irq();
        cfg(4'b0101, 4'b0000, 6'b0);
        wr(2'd1, 4'b0100);
        chk("R9 enable set", int_en, 4'b0100);
        chk("R11 no flag no irq", irq, 0);
        wr(2'd1, 4'b0001);
        chk("R9 zero bits kept", int_en, 4'b0101);
        gen_evt = 4'b0001;
        nx();
        gen_evt = '0;
        chk("R11 irq on enabled flag", irq, 1);
        wr(2'd3, 4'b0100);
        chk("R11 irq drops on clear", irq, 0);
        gen_evt = 4'b0001;
        nx();
        gen_evt = '0;
        chk("R11 irq again", irq, 1);
        wr(2'd2, 4'b0100);
        chk("R9 enable cleared", int_en, 4'b0001);
        chk("R11 irq drops on disable", irq, 0);
    endtask

    initial begin
        nx();
        t_reset();
        t_sync_select();
        t_resync();
        t_async();
        t_soft();
        t_busy();
        t_ready();
        t_overrun();
        t_setwins();
        t_irq();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #(200000 * 5);
        n_err++;
        n_chk++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule